// File: doc/BRIEF.md
# Byte-wide flash bus-mode controller

This block models the control logic of a byte-wide NOR-style flash memory in synthesizable form. It takes the active-low power-down, chip-select, output-enable and write-enable pins, together with the address and data bus, and works out which bus mode the device is in. It steers the 8-bit data bus and its tri-state enable. Command bytes written over the bus select how a read is answered. A read can return a byte of the storage array, a fixed identifier byte, or the status byte. A two-step write sequence starts a byte program or a block erase.

An internal write engine runs each program or erase for a fixed number of clock cycles, with a separate count for each, and drives the ready/busy pin low while it runs. When the count ends, the engine updates the storage array. Program and erase are refused while the program-voltage-valid input is low. Every bus operation is blocked while the supply-lockout input is high. Status bits report the engine's ready state and record why an operation was refused.

Top module: `flash_bus_ctrl`

## Requirements
- R1: `dq_oe_o` is high only while `rp_n_i`=1, `ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1 and `lockout_i`=0. In every other pin combination the bus is released.
- R2: After reset, and while `rp_n_i` is low, reads are in array mode. A low `rp_n_i` aborts any running program or erase without changing memory, forces `ry_by_o` high, clears the pending sequence and clears the status error bits.
- R3: In identifier mode, a read with `addr_i[0]`=0 returns 0x89 and a read with `addr_i[0]`=1 returns 0xA1.
- R4: A command is taken on the clock where `we_n_i` is seen rising while `ce_n_i` is low. The command codes are 0xFF array read, 0x90 identifier read, 0x70 status read, 0x50 clear status, 0x40 program setup and 0x20 erase setup. Any other byte, written with no sequence pending, is ignored.
- R5: A program takes two writes: 0x40, then a data byte at the target address. The new byte equals the old byte AND the data. A single data write with no setup leaves memory unchanged.
- R6: An erase takes two writes: 0x20, then 0xD0. It sets every byte of the block selected by `addr_i[ADDR_W-1:BLK_W]` of the confirm write to 0xFF. Any other second byte cancels the erase and sets status bit 5.
- R7: If `vpp_ok_i` is low at the second write, the program or erase does not start, memory is unchanged and status bit 3 is set. Reads work whatever the level of `vpp_ok_i`.
- R8: While `lockout_i` is high, writes have no effect and the bus is not driven.
- R9: `ry_by_o` is low for exactly PROG_CYC cycles after a program is accepted, and for exactly ERASE_CYC cycles after an erase is accepted. All writes made while it is low are ignored.
- R10: Raising `ce_n_i` does not stop a running program or erase. It completes and updates memory.
- R11: The status byte has bit 7 = ready, bit 5 = erase sequence error and bit 3 = program voltage error, with all other bits 0. Command 0x50 clears bits 5 and 3.
- R12: The second write of a program or erase sequence switches reads to status mode, whether or not the operation was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rp_n_i | input | 1 | Active-low power-down |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| addr_i | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus, write direction |
| dq_o | output | 8 | Data bus, read direction |
| dq_oe_o | output | 1 | Data bus drive enable |
| ry_by_o | output | 1 | Ready (1) / busy (0) |
| vpp_ok_i | input | 1 | Program voltage valid |
| lockout_i | input | 1 | Supply below lockout threshold |

## Verification
The bench builds the block with ADDR_W=4, BLK_W=2, PROG_CYC=3 and ERASE_CYC=7: a 16-byte array in four blocks of four bytes. At this size the bench can program every address, read back the whole array after each operation, and sweep all 32 combinations of the five control pins against the bus-enable rule. The short busy counts keep each program and erase to a few cycles. They still leave room to write commands, read status and pulse power-down in the middle of an erase.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_ID     = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;

  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_STATUS = 2'd2} rd_mode_e;
  typedef enum logic [1:0] {PEND_NONE = 2'd0, PEND_PROG = 2'd1, PEND_ERASE = 2'd2} pend_e;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_e;
endpackage

// File: rtl/flash_pin_decode.sv
module flash_pin_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rp_n_i,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  input  logic lockout_i,
  output logic wr_stb_o,
  output logic drive_o
);
  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_n_i;
  end

  // command taken on rising write enable while selected
  assign wr_stb_o = rp_n_i & ~ce_n_i & ~lockout_i & we_n_i & ~we_q;
  assign drive_o  = rp_n_i & ~ce_n_i & ~oe_n_i & we_n_i & ~lockout_i;
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_bus_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pd_i,
  input  logic     stb_i,
  input  logic     busy_i,
  input  logic     vpp_ok_i,
  input  logic [7:0] data_i,
  output rd_mode_e rd_mode_o,
  output logic     vpp_err_o,
  output logic     seq_err_o,
  output logic     start_o,
  output op_e      op_o
);
  pend_e pend_q;
  logic  take;

  assign take    = stb_i & ~busy_i & ~pd_i;
  assign op_o    = (pend_q == PEND_ERASE) ? OP_ERASE : OP_PROG;
  assign start_o = take & vpp_ok_i &
                   ((pend_q == PEND_PROG) || (pend_q == PEND_ERASE && data_i == CMD_CONFIRM));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_mode_o <= RM_ARRAY;
      pend_q    <= PEND_NONE;
      vpp_err_o <= 1'b0;
      seq_err_o <= 1'b0;
    end else if (pd_i) begin
      rd_mode_o <= RM_ARRAY;
      pend_q    <= PEND_NONE;
      vpp_err_o <= 1'b0;
      seq_err_o <= 1'b0;
    end else if (take) begin
      case (pend_q)
        PEND_PROG: begin
          pend_q    <= PEND_NONE;
          rd_mode_o <= RM_STATUS;
          if (!vpp_ok_i) vpp_err_o <= 1'b1;
        end
        PEND_ERASE: begin
          pend_q    <= PEND_NONE;
          rd_mode_o <= RM_STATUS;
          if (data_i != CMD_CONFIRM) seq_err_o <= 1'b1;
          else if (!vpp_ok_i)        vpp_err_o <= 1'b1;
        end
        default: begin
          case (data_i)
            CMD_RD_ARRAY:  rd_mode_o <= RM_ARRAY;
            CMD_RD_ID:     rd_mode_o <= RM_IDENT;
            CMD_RD_STATUS: rd_mode_o <= RM_STATUS;
            CMD_CLR_STAT: begin
              vpp_err_o <= 1'b0;
              seq_err_o <= 1'b0;
            end
            CMD_PROG:      pend_q <= PEND_PROG;
            CMD_ERASE:     pend_q <= PEND_ERASE;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic              commit_o,
  output op_e               c_op_o,
  output logic [ADDR_W-1:0] c_addr_o,
  output logic [7:0]        c_data_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      c_op_o   <= OP_PROG;
      c_addr_o <= '0;
      c_data_o <= '0;
    end else if (abort_i) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q    <= (op_i == OP_ERASE) ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      c_op_o   <= op_i;
      c_addr_o <= addr_i;
      c_data_o <= data_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign commit_o = (cnt_q == CNT_W'(1)) & ~abort_i;
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter int         BLK_W     = 3,
  parameter int         PROG_CYC  = 16,
  parameter int         ERASE_CYC = 200,
  parameter logic [7:0] MFR_ID    = 8'h89,
  parameter logic [7:0] DEV_ID    = 8'hA1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rp_n_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  output logic              ry_by_o,
  input  logic              vpp_ok_i,
  input  logic              lockout_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_IDX_W = ADDR_W - BLK_W;

  logic              wr_stb, drive, pd;
  rd_mode_e          rd_mode;
  logic              vpp_err, seq_err, wsm_start, busy, commit;
  op_e               start_op, c_op;
  logic [ADDR_W-1:0] c_addr;
  logic [7:0]        c_data, status, rd_data;
  logic [DEPTH-1:0][7:0] mem;

  assign pd = ~rp_n_i;

  flash_pin_decode u_dec (
    .clk_i, .rst_ni, .rp_n_i, .ce_n_i, .oe_n_i, .we_n_i, .lockout_i,
    .wr_stb_o (wr_stb),
    .drive_o  (drive)
  );

  flash_cmd_if u_cmd (
    .clk_i, .rst_ni,
    .pd_i      (pd),
    .stb_i     (wr_stb),
    .busy_i    (busy),
    .vpp_ok_i,
    .data_i    (dq_i),
    .rd_mode_o (rd_mode),
    .vpp_err_o (vpp_err),
    .seq_err_o (seq_err),
    .start_o   (wsm_start),
    .op_o      (start_op)
  );

  flash_wsm #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk_i, .rst_ni,
    .abort_i  (pd),
    .start_i  (wsm_start),
    .op_i     (start_op),
    .addr_i,
    .data_i   (dq_i),
    .busy_o   (busy),
    .commit_o (commit),
    .c_op_o   (c_op),
    .c_addr_o (c_addr),
    .c_data_o (c_data)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic [7:0] byte_q;
    logic       hit_prog, hit_erase;
    assign hit_prog  = commit && c_op == OP_PROG && c_addr == IDX;
    assign hit_erase = commit && c_op == OP_ERASE &&
                       c_addr[ADDR_W-1 -: BLK_IDX_W] == IDX[ADDR_W-1 -: BLK_IDX_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        byte_q <= 8'hFF;
      else if (hit_erase) byte_q <= 8'hFF;
      else if (hit_prog)  byte_q <= byte_q & c_data;
    end
    assign mem[i] = byte_q;
  end

  assign status = {~busy, 1'b0, seq_err, 1'b0, vpp_err, 3'b000};

  always_comb begin
    case (rd_mode)
      RM_IDENT:  rd_data = addr_i[0] ? DEV_ID : MFR_ID;
      RM_STATUS: rd_data = status;
      default:   rd_data = mem[addr_i];
    endcase
  end

  assign dq_oe_o = drive;
  assign dq_o    = drive ? rd_data : 8'h00;
  assign ry_by_o = ~busy | pd;
endmodule

// File: rtl/flash_bus_ctrl_chk.sv
module flash_bus_ctrl_chk
  import flash_bus_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rp_n_i,
  input logic       ce_n_i,
  input logic       oe_n_i,
  input logic       we_n_i,
  input logic       lockout_i,
  input logic [7:0] dq_o,
  input logic       dq_oe_o,
  input logic       ry_by_o,
  input rd_mode_e   rd_mode,
  input logic       wsm_start
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  int low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= 0;
    else if (!ry_by_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  p_drive_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (rp_n_i && !ce_n_i && !oe_n_i && we_n_i && !lockout_i));

  p_pd_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_n_i |-> (ry_by_o && !dq_oe_o));

  p_wake_array_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rp_n_i) |-> (rd_mode == RM_ARRAY));

  p_lock_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |-> !dq_oe_o);

  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ry_by_o |-> (low_cnt < MAXC));

  p_status_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && rd_mode == RM_STATUS) |-> (dq_o[7] == ry_by_o));

  p_auto_status_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wsm_start && rp_n_i) |=> (rd_mode == RM_STATUS || !rp_n_i));
endmodule

bind flash_bus_ctrl flash_bus_ctrl_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rp_n_i    (rp_n_i),
  .ce_n_i    (ce_n_i),
  .oe_n_i    (oe_n_i),
  .we_n_i    (we_n_i),
  .lockout_i (lockout_i),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o),
  .ry_by_o   (ry_by_o),
  .rd_mode   (rd_mode),
  .wsm_start (wsm_start)
);

// File: tb/flash_bus_ctrl_tb.sv
module flash_bus_ctrl_tb;
  localparam int AW = 4, BW = 2, PC = 3, EC = 7, N = 1 << AW;

  logic clk = 0, rst_ni = 0;
  logic rp_n = 1, ce_n = 1, oe_n = 1, we_n = 1, vpp_ok = 1, lock = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dq_i = '0, dq_o;
  logic dq_oe, ry_by;
  logic [7:0] exp_mem [N];
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_bus_ctrl #(.ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) u_dut (
    .clk_i(clk), .rst_ni, .rp_n_i(rp_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .addr_i(addr), .dq_i, .dq_o, .dq_oe_o(dq_oe), .ry_by_o(ry_by),
    .vpp_ok_i(vpp_ok), .lockout_i(lock)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; dq_i = d;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic oe);
    ce_n = 0; oe_n = 0; addr = a; #1;
    d = dq_o; oe = dq_oe;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] d; logic oe;
    rd(a, d, oe);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, d, exp);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ry_by) begin n++; @(negedge clk); end
  endtask

  task automatic chk_array(input string req);
    for (int a = 0; a < N; a++) rd_chk(req, AW'(a), exp_mem[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < N; a++) exp_mem[a] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1 reset oe", {7'd0, dq_oe}, 8'd0);
    chk("R2 reset ready", {7'd0, ry_by}, 8'd1);
    rst_ni = 1;
    @(negedge clk);
    chk_array("R2 array after reset");

    // R1 R8: all control pin combinations
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      {rp_n, ce_n, oe_n, we_n, lock} = 5'(c);
      #1 chk("R1 R8 pin sweep", {7'd0, dq_oe}, {7'd0, rp_n & ~ce_n & ~oe_n & we_n & ~lock});
    end
    @(negedge clk); {rp_n, ce_n, oe_n, we_n, lock} = 5'b11110;
    @(negedge clk);

    // R3 R4 identifier
    wr(0, 8'h90);
    for (int a = 0; a < N; a++) rd_chk("R3 ident", AW'(a), a[0] ? 8'hA1 : 8'h89);
    wr(0, 8'h70);
    rd_chk("R11 R4 status idle", 0, 8'h80);
    wr(0, 8'h3C);
    rd_chk("R4 unknown ignored", 0, 8'h80);
    wr(0, 8'hFF);
    rd_chk("R4 array", 5, 8'hFF);

    // R5 R9 R12 program every address
    for (int a = 0; a < N; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + 11) ^ 8'h6C);
      wr(AW'(a), 8'h40);
      wr(AW'(a), d);
      wait_ready(n);
      chk("R9 program busy length", 8'(n), 8'(PC));
      exp_mem[a] &= d;
      rd_chk("R12 auto status", 0, 8'h80);
    end
    wr(0, 8'hFF);
    chk_array("R5 program sweep");
    wr(5, 8'h40); wr(5, 8'hF0); wait_ready(n);
    exp_mem[5] &= 8'hF0;
    wr(0, 8'hFF);
    rd_chk("R5 program AND", 5, exp_mem[5]);
    wr(3, 8'h12);
    rd_chk("R5 lone write", 3, exp_mem[3]);

    // R6 erase block 1
    wr(4, 8'h20); wr(6, 8'hD0);
    wait_ready(n);
    chk("R9 erase busy length", 8'(n), 8'(EC));
    for (int a = 4; a < 8; a++) exp_mem[a] = 8'hFF;
    rd_chk("R12 status after erase", 0, 8'h80);
    wr(0, 8'hFF);
    chk_array("R6 erase block");

    // R6 bad confirm
    wr(8, 8'h20); wr(8, 8'h55);
    chk("R6 no start", {7'd0, ry_by}, 8'd1);
    rd_chk("R6 R12 seq error", 0, 8'hA0);
    wr(0, 8'h50);
    rd_chk("R11 clear", 0, 8'h80);
    wr(0, 8'hFF);
    chk_array("R6 aborted erase");

    // R7 program voltage low
    vpp_ok = 0;
    wr(2, 8'h40); wr(2, 8'h00);
    chk("R7 no start", {7'd0, ry_by}, 8'd1);
    rd_chk("R7 vpp error", 0, 8'h88);
    wr(0, 8'h20); wr(0, 8'hD0);
    chk("R7 erase no start", {7'd0, ry_by}, 8'd1);
    wr(0, 8'hFF);
    chk_array("R7 reads with vpp low");
    vpp_ok = 1;
    wr(0, 8'h50);
    wr(0, 8'h70);
    rd_chk("R11 clear vpp", 0, 8'h80);

    // R9 R11 writes ignored while busy, status reads busy
    wr(12, 8'h20); wr(12, 8'hD0);
    rd_chk("R11 busy status", 1, 8'h00);
    wr(1, 8'h90);
    wait_ready(n);
    rd_chk("R9 write ignored while busy", 1, 8'h80);
    for (int a = 12; a < 16; a++) exp_mem[a] = 8'hFF;

    // R10 standby during program
    wr(0, 8'h40); wr(0, 8'h00);
    wait_ready(n);
    chk("R10 standby completes", 8'(n), 8'(PC));
    exp_mem[0] = 8'h00;
    wr(0, 8'hFF);
    chk_array("R10 program result");

    // R8 lockout
    lock = 1;
    wr(1, 8'h40); wr(1, 8'h00);
    lock = 0;
    chk("R8 no start", {7'd0, ry_by}, 8'd1);
    rd_chk("R8 mode unchanged", 1, exp_mem[1]);
    wr(0, 8'h70);
    rd_chk("R8 no error", 0, 8'h80);
    wr(0, 8'hFF);
    chk_array("R8 lockout memory");

    // R2 power-down aborts and resets mode and errors
    vpp_ok = 0; wr(0, 8'h40); wr(0, 8'h11); vpp_ok = 1;
    wr(0, 8'h20); wr(0, 8'hD0);
    chk("R2 erase running", {7'd0, ry_by}, 8'd0);
    @(negedge clk); rp_n = 0; ce_n = 0; oe_n = 0;
    #1 chk("R2 pd ready", {7'd0, ry_by}, 8'd1);
    chk("R2 pd tristate", {7'd0, dq_oe}, 8'd0);
    ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    rp_n = 1;
    repeat (EC + 2) @(negedge clk);
    chk("R2 stays ready", {7'd0, ry_by}, 8'd1);
    chk_array("R2 abort keeps memory");
    wr(0, 8'h70);
    rd_chk("R2 errors cleared", 0, 8'h80);
    wr(0, 8'h90);
    @(negedge clk); rp_n = 0; @(negedge clk); rp_n = 1; @(negedge clk);
    rd_chk("R2 wake array", 0, exp_mem[0]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule